// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and presents them to a processor core as one request wire, an 8-bit vector code and a separate non-maskable request. Ordinary lines are sampled into a pending register and gated by a software-programmed enable mask. When exactly one enabled source is pending, the vector names that source. When several are pending, the vector carries one shared code, and software then decides which source to serve first.

The two highest lines do not use the mask path. They are sampled into a non-maskable status register whose OR drives the non-maskable request output. Software reaches the registers over a plain 32-bit word bus with an address, a write strobe, write data and combinational read data. Only the enable mask accepts writes.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While `rst` is high, every register reads zero and `cpu_irq`, `cpu_vector` and `cpu_nmi` are zero.
- R2: A line n in the range 1 to 29 is copied into bit n-1 of the pending register (byte offset 0x04) on each clock edge. The bit follows the level and clears when the line goes low. Bits 29 to 31 of that register read zero.
- R3: Line 0 has no pending bit and affects neither any register nor any output.
- R4: A write strobe at byte offset 0x00 loads the enable mask, which reads back at 0x00. A write to any other offset changes no register and no output.
- R5: The masked register at byte offset 0x08 always reads pending AND mask.
- R6: When exactly one masked bit i is set, `cpu_vector` is 0x31 + i.
- R7: When two or more masked bits are set, `cpu_vector` is 0x30. When none is set, it is 0x00.
- R8: `cpu_irq` is high exactly when `cpu_vector` is non-zero.
- R9: Lines 30 and 31 set and clear bits 30 and 31 of the non-maskable status register (byte offset 0x0C) by level. They never appear in the pending register.
- R10: `cpu_nmi` is high exactly when some bit of the non-maskable status register is set, whatever the mask holds.
- R11: `cpu_vector`, `cpu_irq` and `cpu_nmi` change on the same clock edge that captures the line change or the mask write that causes them.
- R12: Byte offset 0x10, offsets 0x14 to 0x1C, and any offset whose two low bits are non-zero read zero. A write to an unaligned offset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level-sensitive interrupt lines |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Maskable interrupt request |
| cpu_vector | output | 8 | Vector code of the pending request |
| cpu_nmi | output | 1 | Non-maskable interrupt request |

## Verification
The bench first checks the change from one enabled source to two. A design that tests for a non-zero value instead of a single bit would report a source code where the shared 0x30 belongs. It drives line 0, which must stay invisible, and lines 30 and 31 with a zero mask. An off-by-one line mapping or a non-maskable path routed through the mask shows up at once there. Writes to the read-only offsets and to unaligned offsets must leave the mask alone, which catches a decoder that ignores address bits. Edge-exact samples around a mask write show whether the outputs lag a cycle behind the registers.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Word indices of the register map (byte offset = index * 4).
  localparam int unsigned IDX_ENABLE  = 0;
  localparam int unsigned IDX_PEND    = 1;
  localparam int unsigned IDX_ACTIVE  = 2;
  localparam int unsigned IDX_NMI     = 3;
  localparam int unsigned IDX_SPARE   = 4;

  // Vector codes presented to the core.
  localparam logic [7:0] VEC_SHARED_CODE = 8'h30;
  localparam logic [7:0] VEC_FIRST_CODE  = 8'h31;
endpackage

// File: rtl/vic_line_sampler.sv
module vic_line_sampler #(
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_LINES-1:0] pend_d,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] nmi_d,
  output logic [NUM_LINES-1:0] nmi_q
);
  localparam int FIRST_NMI = NUM_LINES - NMI_LINES;

  // Line 0 carries no pending bit.
  logic unused_line0;
  assign unused_line0 = lines[0];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    // Pending bit g is fed by line g+1 when that line is a normal one.
    if (g + 1 < FIRST_NMI) begin : g_norm
      assign pend_d[g] = lines[g+1];
    end else begin : g_none
      assign pend_d[g] = 1'b0;
    end
    // Non-maskable status keeps the line's own index.
    if (g >= FIRST_NMI) begin : g_nmi
      assign nmi_d[g] = lines[g];
    end else begin : g_nonmi
      assign nmi_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      nmi_q  <= '0;
    end else begin
      pend_q <= pend_d;
      nmi_q  <= nmi_d;
    end
  end
endmodule

// File: rtl/vic_mask_reg.sv
module vic_mask_reg #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 aligned,
  input  logic [IDX_W-1:0]     word_idx,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] mask_d,
  output logic [NUM_LINES-1:0] mask_q
);
  import vic_pkg::*;

  logic wr_hit;
  assign wr_hit = wr && aligned && (word_idx == IDX_W'(IDX_ENABLE));
  assign mask_d = wr_hit ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/vic_vector_encode.sv
module vic_vector_encode #(
  parameter int         WIDTH       = 32,
  parameter int         VEC_W       = 8,
  parameter logic [7:0] FIRST_CODE  = 8'h31,
  parameter logic [7:0] SHARED_CODE = 8'h30
) (
  input  logic [WIDTH-1:0] active,
  output logic [VEC_W-1:0] vec,
  output logic             any
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [IW-1:0] low_idx;
  logic          several;

  always_comb begin
    low_idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (active[i]) low_idx = IW'(i);
    end
  end

  // Clearing the lowest set bit leaves something only if two or more are set.
  assign several = |(active & (active - WIDTH'(1)));
  assign any     = |active;

  always_comb begin
    if (!any)         vec = '0;
    else if (several) vec = VEC_W'(SHARED_CODE);
    else              vec = VEC_W'(FIRST_CODE) + VEC_W'(low_idx);
  end
endmodule

// File: rtl/vic_readback.sv
module vic_readback #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 3
) (
  input  logic                 aligned,
  input  logic [IDX_W-1:0]     word_idx,
  input  logic [NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0] pend_q,
  input  logic [NUM_LINES-1:0] nmi_q,
  output logic [NUM_LINES-1:0] rdata
);
  import vic_pkg::*;

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (word_idx)
        IDX_W'(IDX_ENABLE): rdata = mask_q;
        IDX_W'(IDX_PEND):   rdata = pend_q;
        IDX_W'(IDX_ACTIVE): rdata = pend_q & mask_q;
        IDX_W'(IDX_NMI):    rdata = nmi_q;
        IDX_W'(IDX_SPARE):  rdata = '0;
        default:            rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2,
  parameter int ADDR_W    = 5,
  parameter int VEC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 cpu_irq,
  output logic [VEC_W-1:0]     cpu_vector,
  output logic                 cpu_nmi
);
  import vic_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     word_idx;
  logic                 aligned;
  logic [NUM_LINES-1:0] pend_d, pend_q, nmi_d, nmi_q, mask_d, mask_q;
  logic [NUM_LINES-1:0] active_next;
  logic [VEC_W-1:0]     vec_next;
  logic                 any_next;
  logic [VEC_W-1:0]     vec_q;
  logic                 irq_q, nmi_out_q;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);

  vic_line_sampler #(.NUM_LINES(NUM_LINES), .NMI_LINES(NMI_LINES)) u_sampler (
    .clk(clk), .rst(rst), .lines(irq_lines),
    .pend_d(pend_d), .pend_q(pend_q), .nmi_d(nmi_d), .nmi_q(nmi_q)
  );

  vic_mask_reg #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_mask (
    .clk(clk), .rst(rst), .wr(bus_wr), .aligned(aligned),
    .word_idx(word_idx), .wdata(bus_wdata),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  // Outputs are computed from next-state values so that they move on the
  // same edge as the registers software reads.
  assign active_next = pend_d & mask_d;

  vic_vector_encode #(
    .WIDTH(NUM_LINES), .VEC_W(VEC_W),
    .FIRST_CODE(VEC_FIRST_CODE), .SHARED_CODE(VEC_SHARED_CODE)
  ) u_enc (
    .active(active_next), .vec(vec_next), .any(any_next)
  );

  vic_readback #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_rd (
    .aligned(aligned), .word_idx(word_idx),
    .mask_q(mask_q), .pend_q(pend_q), .nmi_q(nmi_q), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= '0;
      irq_q     <= 1'b0;
      nmi_out_q <= 1'b0;
    end else begin
      vec_q     <= vec_next;
      irq_q     <= any_next;
      nmi_out_q <= |nmi_d;
    end
  end

  assign cpu_vector = vec_q;
  assign cpu_irq    = irq_q;
  assign cpu_nmi    = nmi_out_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2,
  parameter int ADDR_W    = 5,
  parameter int VEC_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [NUM_LINES-1:0] bus_wdata,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] pend_q,
  input logic                 cpu_irq,
  input logic [VEC_W-1:0]     cpu_vector,
  input logic                 cpu_nmi
);
  import vic_pkg::*;

  localparam int NORMAL = NUM_LINES - NMI_LINES - 1;

  logic hit_enable, nmi_in;
  assign hit_enable = (bus_addr == '0);
  assign nmi_in     = |irq_lines[NUM_LINES-1:NUM_LINES-NMI_LINES];

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (cpu_vector == '0 && !cpu_irq && !cpu_nmi && mask_q == '0)); // R1

  AST_PEND_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pend_q[0] == $past(irq_lines[1])); // R2

  AST_ENABLE_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!rst && bus_wr && hit_enable) |=> mask_q == $past(bus_wdata)); // R4

  AST_OTHER_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!rst && bus_wr && !hit_enable) |=> $stable(mask_q)); // R4

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cpu_vector == '0 || cpu_vector == VEC_W'(VEC_SHARED_CODE) ||
    (cpu_vector >= VEC_W'(VEC_FIRST_CODE) &&
     cpu_vector <  VEC_W'(VEC_FIRST_CODE) + VEC_W'(NORMAL))); // R6

  AST_IRQ_WITH_VECTOR: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (cpu_vector != '0)); // R8

  AST_NMI_RAISE: assert property (@(posedge clk) disable iff (rst)
    (!rst && nmi_in) |=> cpu_nmi); // R10

  AST_NMI_DROP: assert property (@(posedge clk) disable iff (rst)
    (!rst && !nmi_in) |=> !cpu_nmi); // R10
endmodule

bind vec_irq_ctrl vic_checker #(
  .NUM_LINES(NUM_LINES), .NMI_LINES(NMI_LINES), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) u_checker (
  .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mask_q(mask_q), .pend_q(pend_q),
  .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .cpu_nmi(cpu_nmi)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  logic [7:0]  cpu_vector;
  logic        cpu_nmi;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .cpu_nmi(cpu_nmi)
  );

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] mask;
    logic [7:0]  vec;
    logic        irq;
    logic        nmi;
  } row_t;

  localparam int NROWS = 13;
  localparam row_t ROWS [NROWS] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 8'h00, 1'b0, 1'b0},
    '{32'h0000_0002, 32'hFFFF_FFFF, 8'h31, 1'b1, 1'b0},
    '{32'h2000_0000, 32'hFFFF_FFFF, 8'h4D, 1'b1, 1'b0},
    '{32'h0000_0220, 32'hFFFF_FFFF, 8'h30, 1'b1, 1'b0},
    '{32'h0000_0220, 32'h0000_0010, 8'h35, 1'b1, 1'b0},
    '{32'h0000_0020, 32'h0000_0000, 8'h00, 1'b0, 1'b0},
    '{32'h4000_0000, 32'h0000_0000, 8'h00, 1'b0, 1'b1},
    '{32'h8000_0008, 32'h0000_0004, 8'h33, 1'b1, 1'b1},
    '{32'h0000_0001, 32'hFFFF_FFFF, 8'h00, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 8'h00, 1'b0, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0080, 8'h38, 1'b1, 1'b1},
    '{32'hC000_0000, 32'hFFFF_FFFF, 8'h00, 1'b0, 1'b1},
    '{32'h6000_0000, 32'hFFFF_FFFF, 8'h4D, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, raw;
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 32; a += 4) begin
      bus_read(5'(a), rd);
      check("R1 register zero in reset", rd, 32'h0);
    end
    check("R1 vector zero in reset", {24'h0, cpu_vector}, 32'h0);
    check("R1 irq/nmi low in reset", {30'h0, cpu_irq, cpu_nmi}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R2 R3 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NROWS; i++) begin
      bus_write(5'h00, ROWS[i].mask);
      set_lines(ROWS[i].lines);
      raw = (ROWS[i].lines >> 1) & 32'h1FFF_FFFF;
      check("R6 R7 vector", {24'h0, cpu_vector}, {24'h0, ROWS[i].vec});
      check("R8 irq", {31'h0, cpu_irq}, {31'h0, ROWS[i].irq});
      check("R10 nmi", {31'h0, cpu_nmi}, {31'h0, ROWS[i].nmi});
      bus_read(5'h04, rd);
      check("R2 R3 pending", rd, raw);
      bus_read(5'h08, rd);
      check("R5 masked", rd, raw & ROWS[i].mask);
      bus_read(5'h0C, rd);
      check("R9 nmi status", rd, ROWS[i].lines & 32'hC000_0000);
      bus_read(5'h00, rd);
      check("R4 mask readback", rd, ROWS[i].mask);
    end

    // R4: writes elsewhere ignored (including unaligned, R12)
    bus_write(5'h00, 32'h0000_00F0);
    set_lines(32'h0000_0040);              // raw bit 5 -> 0x36
    check("R4 setup vector", {24'h0, cpu_vector}, 32'h36);
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_write(5'h10, 32'hFFFF_FFFF);
    bus_write(5'h01, 32'h0000_0000);
    bus_read(5'h00, rd);
    check("R4 mask kept", rd, 32'h0000_00F0);
    bus_read(5'h04, rd);
    check("R4 pending kept", rd, 32'h0000_0020);
    check("R4 vector kept", {24'h0, cpu_vector}, 32'h36);
    check("R12 unaligned write ignored irq", {31'h0, cpu_irq}, 32'h1);

    // R12: reserved, undefined and unaligned offsets read zero
    bus_write(5'h00, 32'hFFFF_FFFF);
    set_lines(32'hFFFF_FFFF);
    bus_read(5'h10, rd); check("R12 offset 0x10", rd, 32'h0);
    bus_read(5'h14, rd); check("R12 offset 0x14", rd, 32'h0);
    bus_read(5'h18, rd); check("R12 offset 0x18", rd, 32'h0);
    bus_read(5'h1C, rd); check("R12 offset 0x1C", rd, 32'h0);
    bus_read(5'h02, rd); check("R12 unaligned read", rd, 32'h0);

    // R11: outputs move on the capturing edge, not before and not later
    set_lines(32'h0000_0000);
    @(negedge clk);
    irq_lines = 32'h0000_0004;             // raw bit 1 -> 0x32
    #1 check("R11 vector before edge", {24'h0, cpu_vector}, 32'h0);
    @(posedge clk); #1;
    check("R11 vector after line edge", {24'h0, cpu_vector}, 32'h32);
    @(negedge clk);
    bus_addr = 5'h00; bus_wdata = 32'h0; bus_wr = 1'b1;
    #1 check("R11 vector before mask edge", {24'h0, cpu_vector}, 32'h32);
    @(posedge clk); #1;
    check("R11 vector after mask edge", {24'h0, cpu_vector}, 32'h0);
    check("R11 irq after mask edge", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    irq_lines = 32'h8000_0000;
    @(posedge clk); #1;
    check("R11 nmi after line edge", {31'h0, cpu_nmi}, 32'h1);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    irq_lines = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1 vector cleared", {24'h0, cpu_vector}, 32'h0);
    check("R1 nmi cleared", {31'h0, cpu_nmi}, 32'h0);
    bus_read(5'h0C, rd); check("R1 nmi status cleared", rd, 32'h0);
    bus_read(5'h00, rd); check("R1 mask cleared", rd, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule